// File: doc/BRIEF.md
# I2C Slave with Ten-Bit Addressing

This block is a bus target that answers one ten-bit address on a two-wire serial bus. It samples the serial clock and data lines through a synchroniser running on the system clock and finds start, repeated start and stop conditions. It pulls either line low through open-drain enables. It can receive bytes written by the bus master and send bytes the master reads.

A master reaches the block in two phases. It first writes a header byte that carries the tag pattern and the top two address bits. It then writes a second byte with the low eight address bits. To read, the master issues a repeated start and sends the header again with the direction bit set. The block then holds the clock low until the host has loaded a byte and set the release bit. It holds the clock again after every transmitted byte that the master acknowledges, so the host can supply the next one.

The host side consists of a transmit-data input with a write strobe, a release-set strobe, the last received byte, a set of status flags and a one-cycle interrupt pulse.

Top module: `i2c10_slave`

## Requirements
- R1: After reset, every output flag is 0 and neither line is pulled. SDA falling while SCL is high sets `start_seen` and clears `stop_seen`. SDA rising while SCL is high sets `stop_seen` and clears `start_seen`. After a stop the block pulls neither line.
- R2: A header byte equal to {1,1,1,1,0, own_addr[9], own_addr[8], 0}, sent MSB first, is acknowledged: the block pulls SDA low during the 9th clock.
- R3: A header byte whose upper seven bits do not match is not acknowledged. Every later byte is also left unacknowledged until the next start.
- R4: After an acknowledged write header, a second byte equal to own_addr[7:0] is acknowledged. At the end of its 9th clock the block sets `rx_data` to that byte, clears `is_data` and pulses `irq`.
- R5: A second byte that differs from own_addr[7:0] is not acknowledged and raises no interrupt.
- R6: Data bytes written after a full address match are acknowledged. Each one is placed in `rx_data`, sets `is_data` and pulses `irq` at the end of its 9th clock.
- R7: After a repeated start, a header with the read bit (bit 0 = 1) is acknowledged if the full address matched earlier in the same transfer. At the end of its 9th clock the block holds SCL low, clears `clk_rel`, sets `is_read` and pulses `irq`.
- R8: A read header that arrives without an earlier full match in the same transfer (for example, right after a stop) is not acknowledged and does not hold SCL.
- R9: A `tx_wr` strobe sets `tx_full`. The clock hold stays in force until `rel_set` is strobed. The loaded byte then goes out D7 first over 8 clocks, and `tx_full` clears when shifting begins.
- R10: If the master acknowledges a transmitted byte (SDA low on the 9th clock), then at the end of that clock the block holds SCL low, clears `clk_rel` and pulses `irq`.
- R11: If the master does not acknowledge a transmitted byte, the block neither holds SCL nor pulses `irq`.
- R12: The block starts pulling SDA only while SCL is low.
- R13: `irq` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| scl_oe | output | 1 | Pull serial clock low (clock hold) |
| sda_oe | output | 1 | Pull serial data low |
| own_addr | input | 10 | Ten-bit address this target answers |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | Load `tx_data` into the transmit buffer |
| rel_set | input | 1 | Set the clock-release bit |
| rx_data | output | 8 | Last acknowledged received byte |
| start_seen | output | 1 | Start condition seen last |
| stop_seen | output | 1 | Stop condition seen last |
| is_data | output | 1 | Last received byte was data (1) or address (0) |
| is_read | output | 1 | Current transfer is a master read |
| tx_full | output | 1 | Transmit buffer holds an unsent byte |
| clk_rel | output | 1 | Clock-release bit |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The checker watches, on every cycle, the rules that hold at all times. These are: SDA is only newly pulled while the synchronised SCL is low; the interrupt lasts one cycle; a clock hold never begins with the release bit set; the transmit buffer only empties during a hold; and the start and stop flags never both read 1. Other behaviour depends on the address and on what happens on the bus, and only the bench's scenarios can show it. That covers header and low-byte matching and mismatch, the rule that a read header is honoured only after a full match, the D7-first byte order, and the different endings after a master acknowledge or no acknowledge.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam logic [4:0] HDR_TAG = 5'b11110;

    typedef enum logic [2:0] {
        MD_IDLE,
        MD_HDR1,
        MD_HDR2,
        MD_WDATA,
        MD_TX,
        MD_SKIP
    } mode_e;

    typedef struct packed {
        logic start_seen;
        logic stop_seen;
        logic is_data;
        logic is_read;
        logic tx_full;
        logic clk_rel;
    } stat_t;

    function automatic logic [6:0] hdr_upper(input logic [ADDR_W-1:0] a);
        return {HDR_TAG, a[ADDR_W-1:ADDR_W-2]};
    endfunction

endpackage

// File: rtl/i2c10_line_sync.sv
module i2c10_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall_d,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_prev, sda_prev, fall_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe   <= '1;
            sda_pipe   <= '1;
            scl_prev   <= 1'b1;
            sda_prev   <= 1'b1;
            scl_fall_d <= 1'b0;
        end else begin
            scl_pipe   <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe   <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev   <= scl_s;
            sda_prev   <= sda_s;
            scl_fall_d <= fall_now;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign fall_now  = ~scl_s & scl_prev;
    assign start_det = sda_prev & ~sda_s & scl_s & scl_prev;
    assign stop_det  = ~sda_prev & sda_s & scl_s & scl_prev;

endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
    import i2c10_pkg::*;
(
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              hi_match,
    output logic              lo_match,
    output logic              rd_bit
);
    assign hi_match = (byte_in[BYTE_W-1:1] == hdr_upper(own_addr));
    assign lo_match = (byte_in == own_addr[BYTE_W-1:0]);
    assign rd_bit   = byte_in[0];
endmodule

// File: rtl/i2c10_slave.sv
module i2c10_slave
    import i2c10_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_wr,
    input  logic              rel_set,
    output logic [BYTE_W-1:0] rx_data,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              is_data,
    output logic              is_read,
    output logic              tx_full,
    output logic              clk_rel,
    output logic              irq
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic hi_match, lo_match, rd_bit;

    mode_e             mode, nxt_q, nxt_now;
    stat_t             st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, tx_buf;
    logic              sda_drv, scl_hold, hold_arm, matched, ack_q, ack_now, m_ack;

    i2c10_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall_d(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c10_addr_match u_match (
        .own_addr(own_addr), .byte_in(shreg),
        .hi_match(hi_match), .lo_match(lo_match), .rd_bit(rd_bit)
    );

    // acknowledge decision for a completed received byte
    always_comb begin
        ack_now = 1'b0;
        nxt_now = MD_SKIP;
        case (mode)
            MD_HDR1: begin
                if (hi_match && !rd_bit) begin
                    ack_now = 1'b1;
                    nxt_now = MD_HDR2;
                end else if (hi_match && rd_bit && matched) begin
                    ack_now = 1'b1;
                    nxt_now = MD_TX;
                end
            end
            MD_HDR2: begin
                if (lo_match) begin
                    ack_now = 1'b1;
                    nxt_now = MD_WDATA;
                end
            end
            MD_WDATA: begin
                ack_now = 1'b1;
                nxt_now = MD_WDATA;
            end
            default: begin
                ack_now = 1'b0;
                nxt_now = MD_SKIP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MD_IDLE;
            nxt_q    <= MD_SKIP;
            st       <= '0;
            cnt      <= '0;
            shreg    <= '0;
            tx_buf   <= '0;
            rx_data  <= '0;
            sda_drv  <= 1'b0;
            scl_hold <= 1'b0;
            hold_arm <= 1'b0;
            matched  <= 1'b0;
            ack_q    <= 1'b0;
            m_ack    <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (hold_arm) begin
                scl_hold <= 1'b0;
                hold_arm <= 1'b0;
            end
            if (rel_set) st.clk_rel <= 1'b1;
            if (tx_wr) tx_buf <= tx_data;

            if (stop_det) begin
                mode         <= MD_IDLE;
                matched      <= 1'b0;
                sda_drv      <= 1'b0;
                scl_hold     <= 1'b0;
                hold_arm     <= 1'b0;
                cnt          <= '0;
                st.stop_seen <= 1'b1;
                st.start_seen <= 1'b0;
            end else if (start_det) begin
                mode          <= MD_HDR1;
                cnt           <= '0;
                sda_drv       <= 1'b0;
                st.start_seen <= 1'b1;
                st.stop_seen  <= 1'b0;
                st.is_read    <= 1'b0;
            end else if (mode == MD_TX && scl_hold && st.clk_rel && !hold_arm) begin
                // place D7 while SCL is still held, release next cycle
                sda_drv    <= ~tx_buf[BYTE_W-1];
                shreg      <= tx_buf;
                st.tx_full <= 1'b0;
                hold_arm   <= 1'b1;
                cnt        <= '0;
            end else if (mode != MD_IDLE) begin
                if (scl_rise && cnt <= CNT_ACK) begin
                    if (cnt < CNT_ACK && mode != MD_TX)
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                    if (cnt == CNT_ACK && mode == MD_TX)
                        m_ack <= ~sda_s;
                    cnt <= cnt + 1'b1;
                end
                if (scl_fall) begin
                    if (cnt == CNT_ACK) begin
                        if (mode == MD_TX) begin
                            sda_drv <= 1'b0;
                        end else begin
                            sda_drv <= ack_now;
                            ack_q   <= ack_now;
                            nxt_q   <= nxt_now;
                        end
                    end else if (cnt == CNT_END) begin
                        sda_drv <= 1'b0;
                        cnt     <= '0;
                        if (mode == MD_TX) begin
                            if (m_ack) begin
                                scl_hold   <= 1'b1;
                                st.clk_rel <= 1'b0;
                                irq        <= 1'b1;
                            end else begin
                                mode <= MD_SKIP;
                            end
                        end else begin
                            mode <= nxt_q;
                            if (ack_q) begin
                                rx_data    <= shreg;
                                st.is_data <= (mode == MD_WDATA);
                                if (mode == MD_HDR2) matched <= 1'b1;
                                if (mode == MD_HDR1 && nxt_q == MD_HDR2) matched <= 1'b0;
                                if (mode != MD_HDR1 || nxt_q == MD_TX) irq <= 1'b1;
                                if (nxt_q == MD_TX) begin
                                    scl_hold   <= 1'b1;
                                    st.clk_rel <= 1'b0;
                                    st.is_read <= 1'b1;
                                end
                            end
                        end
                    end else if (mode == MD_TX && cnt != '0) begin
                        sda_drv <= ~shreg[BYTE_W-2];
                        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                    end
                end
            end

            if (tx_wr) st.tx_full <= 1'b1;
        end
    end

    assign sda_oe     = sda_drv;
    assign scl_oe     = scl_hold;
    assign start_seen = st.start_seen;
    assign stop_seen  = st.stop_seen;
    assign is_data    = st.is_data;
    assign is_read    = st.is_read;
    assign tx_full    = st.tx_full;
    assign clk_rel    = st.clk_rel;

endmodule

// File: rtl/i2c10_slave_chk.sv
module i2c10_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic sda_oe,
    input logic scl_oe,
    input logic irq,
    input logic start_seen,
    input logic stop_seen,
    input logic tx_full,
    input logic clk_rel
);
    AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);  // R12

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);  // R13

    AST_HOLD_WITH_REL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_oe) |-> !clk_rel);  // R10

    AST_TXFULL_DRAIN_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_full) |-> scl_oe);  // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(start_seen && stop_seen));  // R1

    AST_NO_HOLD_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_seen |-> !scl_oe);  // R1
endmodule

bind i2c10_slave i2c10_slave_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .irq(irq), .start_seen(start_seen), .stop_seen(stop_seen),
    .tx_full(tx_full), .clk_rel(clk_rel)
);

// File: tb/i2c10_slave_bench.sv
module i2c10_slave_bench;
    localparam int H = 12;
    localparam logic [9:0] ADDR = 10'h2B5;
    localparam logic [7:0] HDR_W = 8'hF4;   // 11110_10_0
    localparam logic [7:0] HDR_R = 8'hF5;   // 11110_10_1
    localparam logic [7:0] LO    = 8'hB5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_sda_low = 1'b0, m_scl_low = 1'b0;
    logic scl_oe, sda_oe, scl_bus, sda_bus;
    logic [7:0] tx_data = '0, rx_data;
    logic tx_wr = 1'b0, rel_set = 1'b0;
    logic start_seen, stop_seen, is_data, is_read, tx_full, clk_rel, irq;
    int n_chk = 0, n_err = 0, irq_n = 0;

    always #4 clk = ~clk;

    assign scl_bus = !(m_scl_low || scl_oe);
    assign sda_bus = !(m_sda_low || sda_oe);

    i2c10_slave u_i2c10_slave (
        .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(ADDR),
        .tx_data(tx_data), .tx_wr(tx_wr), .rel_set(rel_set),
        .rx_data(rx_data), .start_seen(start_seen), .stop_seen(stop_seen),
        .is_data(is_data), .is_read(is_read), .tx_full(tx_full),
        .clk_rel(clk_rel), .irq(irq)
    );

    always @(posedge clk) if (!rst && irq) irq_n++;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0; wait_clks(H);
        m_sda_low = 1'b1; wait_clks(H);
        m_scl_low = 1'b1; wait_clks(H);
    endtask

    task automatic m_rstart();
        wait_clks(2); m_sda_low = 1'b0; wait_clks(H);
        m_scl_low = 1'b0; wait_high(); wait_clks(H);
        m_sda_low = 1'b1; wait_clks(H);
        m_scl_low = 1'b1; wait_clks(H);
    endtask

    task automatic m_stop();
        wait_clks(2); m_sda_low = 1'b1; wait_clks(H);
        m_scl_low = 1'b0; wait_high(); wait_clks(H);
        m_sda_low = 1'b0; wait_clks(H);
    endtask

    task automatic m_write(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wait_clks(2); m_sda_low = !b[i]; wait_clks(H);
            m_scl_low = 1'b0; wait_high(); wait_clks(H);
            m_scl_low = 1'b1;
        end
        wait_clks(2); m_sda_low = 1'b0; wait_clks(H);
        m_scl_low = 1'b0; wait_high(); wait_clks(H/2);
        ack = !sda_bus;
        wait_clks(H/2); m_scl_low = 1'b1; wait_clks(H);
    endtask

    task automatic m_read(input logic give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_clks(H); m_scl_low = 1'b0; wait_high(); wait_clks(H/2);
            b[i] = sda_bus;
            wait_clks(H/2); m_scl_low = 1'b1;
        end
        wait_clks(2); m_sda_low = give_ack; wait_clks(H);
        m_scl_low = 1'b0; wait_high(); wait_clks(H);
        m_scl_low = 1'b1; wait_clks(2); m_sda_low = 1'b0; wait_clks(H);
    endtask

    task automatic host_load(input logic [7:0] b);
        tx_data = b; tx_wr = 1'b1; wait_clks(1); tx_wr = 1'b0; wait_clks(1);
    endtask

    task automatic host_release();
        rel_set = 1'b1; wait_clks(1); rel_set = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R1 reset scl_oe", scl_oe, 0);
        chk("R1 reset flags", {start_seen, stop_seen, is_data, is_read, tx_full, clk_rel, irq}, 0);
    endtask

    task automatic t_write_path();
        logic a; int i0;
        m_start();
        chk("R1 start_seen", start_seen, 1);
        chk("R1 stop_seen after start", stop_seen, 0);
        m_write(HDR_W, a); chk("R2 write header ack", a, 1);
        i0 = irq_n;
        m_write(LO, a); chk("R4 low byte ack", a, 1);
        chk("R4 irq", irq_n - i0, 1);
        chk("R4 rx_data", rx_data, LO);
        chk("R4 is_data", is_data, 0);
        m_write(8'hA5, a); chk("R6 data ack", a, 1);
        chk("R6 rx_data", rx_data, 8'hA5);
        chk("R6 is_data", is_data, 1);
        m_write(8'h3C, a); chk("R6 second data ack", a, 1);
        chk("R6 second rx_data", rx_data, 8'h3C);
        chk("R6 irq count", irq_n - i0, 3);
        m_stop();
        chk("R1 stop_seen", stop_seen, 1);
        chk("R1 start_seen after stop", start_seen, 0);
        chk("R1 no pull after stop", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_bad_upper();
        logic a; int i0;
        i0 = irq_n;
        m_start();
        m_write(8'hF2, a); chk("R3 wrong upper nack", a, 0);
        m_write(LO, a);    chk("R3 later byte ignored", a, 0);
        chk("R3 no irq", irq_n - i0, 0);
        m_stop();
    endtask

    task automatic t_bad_lower();
        logic a; int i0;
        i0 = irq_n;
        m_start();
        m_write(HDR_W, a); chk("R2 header ack again", a, 1);
        m_write(8'hB4, a); chk("R5 wrong low byte nack", a, 0);
        m_write(8'h11, a); chk("R5 data after mismatch nack", a, 0);
        chk("R5 no irq", irq_n - i0, 0);
        m_stop();
    endtask

    task automatic t_read_path();
        logic a; logic [7:0] b; int i0;
        m_start();
        m_write(HDR_W, a); m_write(LO, a);
        m_rstart();
        i0 = irq_n;
        m_write(HDR_R, a); chk("R7 read header ack", a, 1);
        chk("R7 scl held", scl_oe, 1);
        chk("R7 is_read", is_read, 1);
        chk("R7 clk_rel cleared", clk_rel, 0);
        chk("R7 irq", irq_n - i0, 1);
        wait_clks(40);
        chk("R9 hold persists", scl_oe, 1);
        host_load(8'hC6);
        chk("R9 tx_full set", tx_full, 1);
        chk("R9 hold before release", scl_oe, 1);
        host_release();
        i0 = irq_n;
        m_read(1'b1, b);
        chk("R9 byte D7 first", b, 8'hC6);
        chk("R9 tx_full cleared", tx_full, 0);
        chk("R10 hold after ack", scl_oe, 1);
        chk("R10 clk_rel cleared", clk_rel, 0);
        chk("R10 irq", irq_n - i0, 1);
        host_load(8'h5A);
        host_release();
        i0 = irq_n;
        m_read(1'b0, b);
        chk("R9 second byte", b, 8'h5A);
        chk("R11 no hold after nack", scl_oe, 0);
        chk("R11 no irq after nack", irq_n - i0, 0);
        m_stop();
    endtask

    task automatic t_read_no_match();
        logic a;
        m_start();
        m_write(HDR_R, a); chk("R8 read header without match nack", a, 0);
        chk("R8 no hold", scl_oe, 0);
        m_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(5);
        t_reset();
        t_write_path();
        t_bad_upper();
        t_bad_lower();
        t_read_path();
        t_read_no_match();
        wait_clks(10);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule